// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block lets several processors pass 32-bit messages to one another through six independent first-in first-out queues, each holding four entries. A processor posts a message by writing a queue's message register and collects the oldest message by reading the same address. Every queue exposes a full flag and an occupancy count, so software can poll without consuming anything.

Four users, each normally one processor, own an interrupt status word and an interrupt enable word. Every accepted push raises a "message arrived" event for its queue. Every pop that takes a queue out of the full state raises a "space available" event. Both events are posted to all four users. Status bits are cleared by writing ones. Each user has one interrupt line, which is high while any enabled status bit is set. A revision word, an idle-mode configuration word and a constant status word complete the map. All accesses use a simple single-cycle register bus with a registered read port.

Top module: `mbox_hub`

## Requirements
- R1: After reset every queue is empty (count 0, full flag 0), every interrupt status and enable word is 0, the configuration word is 0 and all interrupt lines are low. A reset asserted mid-run discards any queued messages.
- R2: A write to offset 0x40+4n (n = 0..5) appends the write data to queue n. A read of that offset returns and removes the oldest entry. Entries leave in arrival order, and the queues do not affect one another.
- R3: Each queue holds 4 entries. The word at 0x80+4n reads 1 while queue n is full and 0 otherwise. A write to a full queue is discarded and leaves the queue's contents unchanged.
- R4: The word at 0xC0+4n reads the number of entries currently held in queue n.
- R5: A read of an empty queue's message offset returns 0 and leaves its count at 0.
- R6: An accepted push into queue n sets bit 2n of the status word of every user. Status word u sits at 0x100+8u, for u = 0..3.
- R7: A pop from a full queue n sets bit 2n+1 of every user's status word.
- R8: Writing a status word clears each bit written as 1 and keeps each bit written as 0. Other users' status words are unaffected. An event arriving in the same cycle as the clear wins.
- R9: The enable word of user u at 0x104+8u is read/write. The interrupt output irq_o[u] is high in the cycle after (status & enable) of user u is nonzero, and low in the cycle after it is zero.
- R10: Offset 0x00 reads the revision constant (default 0x20). Offset 0x14 reads 1. Offset 0x10 stores bit 0 (auto-idle) and bit 4 (smart-idle) and reads them back, with all other bits reading 0.
- R11: Read data appears on bus_rdata on the clock edge that samples bus_rd and reads 0 when no read was made. If bus_wr and bus_rd are both high, only the write takes place and the read returns 0.
- R12: Writes to unmapped offsets have no effect, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | N_USERS (4) | One interrupt line per user |

## Verification
Each push, pop, clear and configuration write takes effect on the edge that samples the strobe. Read data is registered on that same edge, so the bench drives strobes on the falling edge and samples bus_rdata on the next falling edge. An interrupt line lags its status and enable state by one further register. The bench therefore checks irq_o both on the falling edge right after the triggering write, where it must not yet have moved, and one cycle later, where it must have. The table-driven part runs reads right after the writes they depend on. The count and full flags are thus checked exactly one access after each push or pop.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  // byte offsets of the register map
  localparam int OFF_REV    = 'h000;
  localparam int OFF_CFG    = 'h010;
  localparam int OFF_SSTAT  = 'h014;
  localparam int OFF_MSG    = 'h040;
  localparam int OFF_FULL   = 'h080;
  localparam int OFF_LEVEL  = 'h0C0;
  localparam int OFF_IRQ    = 'h100;
  localparam int IRQ_STRIDE = 8;
  localparam int WORD_BYTES = 4;
  // configuration bits kept: bit 0 auto-idle, bit 4 smart-idle
  localparam logic [31:0] CFG_KEEP = 32'h0000_0011;

  typedef struct packed {
    logic arrived;
    logic space;
  } qev_t;
endpackage

// File: rtl/mbox_queue.sv
`timescale 1ns/1ps
module mbox_queue #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output mbox_pkg::qev_t    ev
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              push_ok, pop_ok;

  assign full    = (level == CNT_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  assign ev.arrived = push_ok;
  assign ev.space   = pop_ok & full;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  assign head = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(level) && $stable(wptr));
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (level == '0) && $stable(rptr));
  p_space_from_full_r7: assert property (@(posedge clk) disable iff (rst)
    ev.space |=> (level == CNT_W'(DEPTH - 1)));
endmodule

// File: rtl/mbox_user_irq.sv
`timescale 1ns/1ps
module mbox_user_irq #(
  parameter int EV_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EV_W-1:0] ev_set,
  input  logic            stat_we,
  input  logic            en_we,
  input  logic [EV_W-1:0] wdata,
  output logic [EV_W-1:0] status,
  output logic [EV_W-1:0] enable,
  output logic            irq
);
  logic [EV_W-1:0] clr;

  assign clr = stat_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr) | ev_set;
      if (en_we) enable <= wdata;
      irq <= |(status & enable);
    end
  end

  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    stat_we |=> ((status & $past(wdata & ~ev_set)) == '0));
  p_event_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (|ev_set) |=> ((status & $past(ev_set)) == $past(ev_set)));
  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(status & enable)));
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(status & enable)) |=> !irq);
endmodule

// File: rtl/mbox_hub.sv
`timescale 1ns/1ps
module mbox_hub #(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 12,
  parameter int          N_QUEUES = 6,
  parameter int          N_USERS  = 4,
  parameter int          DEPTH    = 4,
  parameter logic [31:0] REV      = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_USERS-1:0] irq_o
);
  import mbox_pkg::*;

  localparam int EV_W  = 2 * N_QUEUES;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              rd_go;
  logic [N_QUEUES-1:0] hit_msg, hit_full, hit_lvl;
  logic [N_QUEUES-1:0] q_push, q_pop, q_full, q_empty;
  logic [DATA_W-1:0] q_head [N_QUEUES];
  logic [CNT_W-1:0]  q_lvl  [N_QUEUES];
  qev_t              q_ev   [N_QUEUES];
  logic [EV_W-1:0]   ev_vec;
  logic [N_USERS-1:0] hit_stat, hit_en;
  logic [EV_W-1:0]   u_stat [N_USERS];
  logic [EV_W-1:0]   u_en   [N_USERS];
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] rd_mux;

  // a write takes precedence: a read in the same cycle is not performed
  assign rd_go = bus_rd & ~bus_wr;

  for (genvar n = 0; n < N_QUEUES; n++) begin : g_q
    assign hit_msg[n]  = (bus_addr == ADDR_W'(OFF_MSG   + WORD_BYTES * n));
    assign hit_full[n] = (bus_addr == ADDR_W'(OFF_FULL  + WORD_BYTES * n));
    assign hit_lvl[n]  = (bus_addr == ADDR_W'(OFF_LEVEL + WORD_BYTES * n));
    assign q_push[n]   = bus_wr & hit_msg[n];
    assign q_pop[n]    = rd_go  & hit_msg[n];

    mbox_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst   (rst),
      .push  (q_push[n]),
      .pop   (q_pop[n]),
      .din   (bus_wdata),
      .head  (q_head[n]),
      .level (q_lvl[n]),
      .full  (q_full[n]),
      .empty (q_empty[n]),
      .ev    (q_ev[n])
    );

    // interleaved event word: arrival at 2n, space at 2n+1
    assign ev_vec[2*n]   = q_ev[n].arrived;
    assign ev_vec[2*n+1] = q_ev[n].space;

    p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (q_pop[n] && q_empty[n]) |=> (bus_rdata == '0));
    p_push_posts_all_r6: assert property (@(posedge clk) disable iff (rst)
      (q_push[n] && !q_full[n]) |=> u_stat[0][2*n] && u_stat[N_USERS-1][2*n]);
  end

  for (genvar u = 0; u < N_USERS; u++) begin : g_u
    assign hit_stat[u] = (bus_addr == ADDR_W'(OFF_IRQ + IRQ_STRIDE * u));
    assign hit_en[u]   = (bus_addr == ADDR_W'(OFF_IRQ + IRQ_STRIDE * u + WORD_BYTES));

    mbox_user_irq #(.EV_W(EV_W)) u_user (
      .clk     (clk),
      .rst     (rst),
      .ev_set  (ev_vec),
      .stat_we (bus_wr & hit_stat[u]),
      .en_we   (bus_wr & hit_en[u]),
      .wdata   (bus_wdata[EV_W-1:0]),
      .status  (u_stat[u]),
      .enable  (u_en[u]),
      .irq     (irq_o[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(OFF_CFG))
      cfg_q <= bus_wdata & DATA_W'(CFG_KEEP);
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_REV))   rd_mux = DATA_W'(REV);
    if (bus_addr == ADDR_W'(OFF_CFG))   rd_mux = cfg_q;
    if (bus_addr == ADDR_W'(OFF_SSTAT)) rd_mux = DATA_W'(1);
    for (int n = 0; n < N_QUEUES; n++) begin
      if (hit_msg[n])  rd_mux = q_empty[n] ? '0 : q_head[n];
      if (hit_full[n]) rd_mux = DATA_W'(q_full[n]);
      if (hit_lvl[n])  rd_mux = DATA_W'(q_lvl[n]);
    end
    for (int u = 0; u < N_USERS; u++) begin
      if (hit_stat[u]) rd_mux = DATA_W'(u_stat[u]);
      if (hit_en[u])   rd_mux = DATA_W'(u_en[u]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_go ? rd_mux : '0;
  end

  p_no_read_on_write_r11: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (bus_rdata == '0));
  p_cfg_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_q & ~DATA_W'(CFG_KEEP)) == '0);
endmodule

// File: tb/mbox_hub_tb.sv
`timescale 1ns/1ps
module mbox_hub_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  mbox_hub u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  typedef struct packed {
    logic        rd;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h040, 32'hA1A1_0001, 32'h0, 4'd2},          // R2 push q0
    '{1'b0, 12'h040, 32'hA2A2_0002, 32'h0, 4'd2},          // R2
    '{1'b1, 12'h0C0, 32'h0, 32'd2, 4'd4},                  // R4 level
    '{1'b1, 12'h080, 32'h0, 32'd0, 4'd3},                  // R3 not full
    '{1'b1, 12'h040, 32'h0, 32'hA1A1_0001, 4'd2},          // R2 order
    '{1'b1, 12'h040, 32'h0, 32'hA2A2_0002, 4'd2},          // R2
    '{1'b1, 12'h040, 32'h0, 32'h0, 4'd5},                  // R5 empty read
    '{1'b1, 12'h0C0, 32'h0, 32'd0, 4'd5},                  // R5 level stays 0
    '{1'b1, 12'h100, 32'h0, 32'h1, 4'd6},                  // R6 user0 bit0
    '{1'b1, 12'h118, 32'h0, 32'h1, 4'd6},                  // R6 user3 bit0
    '{1'b0, 12'h100, 32'h1, 32'h0, 4'd8},                  // R8 clear user0
    '{1'b1, 12'h100, 32'h0, 32'h0, 4'd8},                  // R8
    '{1'b1, 12'h118, 32'h0, 32'h1, 4'd8},                  // R8 others kept
    '{1'b0, 12'h110, 32'h0, 32'h0, 4'd8},                  // R8 zero write
    '{1'b1, 12'h110, 32'h0, 32'h1, 4'd8},                  // R8 kept
    '{1'b0, 12'h054, 32'hB000_0000, 32'h0, 4'd3},          // R3 fill q5
    '{1'b0, 12'h054, 32'hB000_0001, 32'h0, 4'd3},
    '{1'b0, 12'h054, 32'hB000_0002, 32'h0, 4'd3},
    '{1'b0, 12'h054, 32'hB000_0003, 32'h0, 4'd3},
    '{1'b1, 12'h094, 32'h0, 32'd1, 4'd3},                  // R3 full
    '{1'b0, 12'h054, 32'hDEAD_BEEF, 32'h0, 4'd3},          // R3 dropped
    '{1'b1, 12'h0D4, 32'h0, 32'd4, 4'd4},                  // R4
    '{1'b1, 12'h054, 32'h0, 32'hB000_0000, 4'd2},          // R2
    '{1'b1, 12'h094, 32'h0, 32'd0, 4'd3},                  // R3
    '{1'b1, 12'h108, 32'h0, 32'h0000_0C01, 4'd7},          // R7 bit11
    '{1'b1, 12'h054, 32'h0, 32'hB000_0001, 4'd2},
    '{1'b1, 12'h054, 32'h0, 32'hB000_0002, 4'd2},
    '{1'b1, 12'h054, 32'h0, 32'hB000_0003, 4'd2},
    '{1'b1, 12'h054, 32'h0, 32'h0, 4'd3},                  // R3 drop left no entry
    '{1'b0, 12'h010, 32'hFFFF_FFFF, 32'h0, 4'd10},         // R10
    '{1'b1, 12'h010, 32'h0, 32'h0000_0011, 4'd10},
    '{1'b1, 12'h000, 32'h0, 32'h0000_0020, 4'd10},
    '{1'b1, 12'h014, 32'h0, 32'h1, 4'd10},
    '{1'b0, 12'h200, 32'h1234, 32'h0, 4'd12},              // R12
    '{1'b1, 12'h200, 32'h0, 32'h0, 4'd12},
    '{1'b0, 12'h044, 32'hC0C0_0001, 32'h0, 4'd2},          // R2 q1
    '{1'b1, 12'h0C4, 32'h0, 32'd1, 4'd2},
    '{1'b1, 12'h0C0, 32'h0, 32'd0, 4'd2},                  // q0 untouched
    '{1'b1, 12'h044, 32'h0, 32'hC0C0_0001, 4'd2}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus cycle: drive on falling edge, sample on the next falling edge
  task automatic cyc(input logic w, input logic r, input logic [11:0] a, input logic [31:0] d);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    cyc(1'b0, 1'b1, a, '0);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {28'h0, irq_o}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    for (int n = 0; n < 6; n++) begin
      rd_chk("R1 level", 12'(12'h0C0 + 4*n), 32'h0);
      rd_chk("R1 full", 12'(12'h080 + 4*n), 32'h0);
    end
    for (int u = 0; u < 4; u++) begin
      rd_chk("R1 status", 12'(12'h100 + 8*u), 32'h0);
      rd_chk("R1 enable", 12'(12'h104 + 8*u), 32'h0);
    end
    rd_chk("R1 cfg", 12'h010, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        cyc(1'b0, 1'b1, VEC[i].a, '0);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), bus_rdata, VEC[i].e);
      end else begin
        wr(VEC[i].a, VEC[i].d);
      end
    end

    // R9 interrupt timing
    wr(12'h100, 32'h0000_0FFF);
    wr(12'h104, 32'h0000_0010);
    rd_chk("R9 enable readback", 12'h104, 32'h10);
    check("R9 idle", {31'h0, irq_o[0]}, 32'h0);
    wr(12'h048, 32'h5555_AAAA);
    check("R9 one cycle lag", {31'h0, irq_o[0]}, 32'h0);
    @(negedge clk);
    check("R9 irq high", {31'h0, irq_o[0]}, 32'h1);
    check("R9 other user masked", {31'h0, irq_o[1]}, 32'h0);
    wr(12'h100, 32'h0000_0010);
    check("R9 still high after clear edge", {31'h0, irq_o[0]}, 32'h1);
    @(negedge clk);
    check("R9 irq low", {31'h0, irq_o[0]}, 32'h0);
    rd_chk("R2 q2 drain", 12'h048, 32'h5555_AAAA);

    // R11 write and read together
    cyc(1'b1, 1'b1, 12'h04C, 32'h0000_0077);
    check("R11 read suppressed", bus_rdata, 32'h0);
    rd_chk("R11 write done", 12'h0CC, 32'd1);
    rd_chk("R11 data", 12'h04C, 32'h0000_0077);
    check("R11 idle rdata", bus_rdata, 32'h0000_0077);
    @(negedge clk);
    check("R11 zero without read", bus_rdata, 32'h0);

    // R1 reset mid-run
    wr(12'h040, 32'h1111_2222);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_chk("R1 queue flushed", 12'h0C0, 32'h0);
    rd_chk("R1 status cleared", 12'h100, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule